// File: doc/BRIEF.md
# Four-Way Junction Traffic Sequencer

This block controls the lamps at a crossing of four roads. Each road has a left arrow, a straight arrow, a right arrow, a yellow lamp and a red lamp. Each road also has a pedestrian red lamp and a pedestrian green lamp. That makes 28 lamp outputs in total. After reset every road shows red. The sequencer then serves the roads one at a time in a fixed rotation. Each road gets a green phase, then a yellow phase, then a short red clearance phase, before the next road is served.

The timing is built into the block. A prescaler divides the fast system clock into a one-cycle tick enable, which is one second at the default setting. Each phase lasts a parameterised number of ticks. The lamps are held in registers and are decoded from the current state alone. They change only on the clock edge where a tick completes a phase.

Every lamp port is a 4-bit vector indexed by road: bit 0 is south, bit 1 is west, bit 2 is north and bit 3 is east.

Top module: `tl_junction`

## Requirements
- R1: While reset is asserted, and until the start phase ends, the outputs are as follows. All four vehicle red bits and all four pedestrian red bits are 1. Every other lamp bit is 0.
- R2: Roads are served in the order south (bit 0), west (bit 1), north (bit 2), east (bit 3), then south again. Each road goes through green, yellow and clearance. The start phase never recurs until the next reset.
- R3: In a road's green phase, these lamps are lit:
  - that road's left, straight and right bits;
  - the vehicle red bit of every other road;
  - all four pedestrian green bits.
  All other bits are 0, except as R4 adds.
- R4: While south is green, the east left-arrow bit (bit 3) is also 1.
- R5: In a road's yellow phase, these lamps are lit:
  - that road's yellow bit and left bit;
  - the red bit of every other road;
  - all four pedestrian green bits.
  All other bits are 0.
- R6: In a road's clearance phase, these lamps are lit:
  - that road's left bit;
  - the red bit of every other road;
  - all four pedestrian red bits.
  All other bits are 0.
- R7: The phases last a set number of ticks. Start lasts START_TICKS, green lasts GO_TICKS, yellow lasts AMBER_TICKS and clearance lasts CLEAR_TICKS.
- R8: A tick occurs once every DIV_COUNT clock cycles. The first tick is on the DIV_COUNT-th rising edge after reset is released. Lamps change only on the edge where a tick completes a phase.
- R9: Two roads never have a straight or right bit lit in the same cycle. A road's red bit is never lit in the same cycle as its own straight bit.
- R10: The reset is asynchronous and active high. Asserting it mid-sequence returns the outputs to the R1 pattern without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| turnLeft | output | 4 | Left-arrow lamps, one bit per road |
| goStraight | output | 4 | Straight-arrow lamps |
| turnRight | output | 4 | Right-arrow lamps |
| amber | output | 4 | Yellow lamps |
| stopRed | output | 4 | Vehicle red lamps |
| walkRed | output | 4 | Pedestrian red lamps |
| walkGreen | output | 4 | Pedestrian green lamps |

## Verification
Some properties are checked by assertions on every cycle. These are the conflict rules of R9, pedestrian red and green never lit together, at most one yellow lamp lit, lamps held steady between ticks, and the start state never coming back. Other behaviour can only be shown by the scenarios in the bench. That covers the exact lamp pattern of each phase, the rotation order, the phase lengths counted in ticks, the extra east arrow, and the asynchronous return to all-red. The bench checks these by predicting every cycle's lamp word from the tick count since reset.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [3:0] {
    ST_START,
    ST_S_GO, ST_S_AMB, ST_S_CLR,
    ST_W_GO, ST_W_AMB, ST_W_CLR,
    ST_N_GO, ST_N_AMB, ST_N_CLR,
    ST_E_GO, ST_E_AMB, ST_E_CLR
  } phase_e;

  typedef enum logic [1:0] {PK_START, PK_GO, PK_AMB, PK_CLR} kind_e;

  // strobes from control to the timebase
  typedef struct packed {
    logic  advance;
    kind_e kind;
  } ctrl_s;

  typedef struct packed {
    logic [3:0] left;
    logic [3:0] straight;
    logic [3:0] right;
    logic [3:0] amber;
    logic [3:0] red;
    logic [3:0] walkRed;
    logic [3:0] walkGreen;
  } lamp_s;

  function automatic kind_e kindOf(phase_e s);
    int n;
    kind_e k;
    if (s == ST_START) begin
      k = PK_START;
    end else begin
      n = int'(s) - 1;
      case (n % 3)
        0:       k = PK_GO;
        1:       k = PK_AMB;
        default: k = PK_CLR;
      endcase
    end
    return k;
  endfunction

  function automatic lamp_s lampsFor(phase_e s);
    lamp_s      o;
    logic [3:0] oh;
    int         n;
    o = '0;
    if (s == ST_START) begin
      o.red     = 4'hF;
      o.walkRed = 4'hF;
    end else begin
      n  = int'(s) - 1;
      oh = 4'b0001 << (n / 3);
      o.left = oh;
      o.red  = ~oh;
      case (n % 3)
        0: begin
          o.straight  = oh;
          o.right     = oh;
          o.walkGreen = 4'hF;
          if (oh[0]) o.left[3] = 1'b1;
        end
        1: begin
          o.amber     = oh;
          o.walkGreen = 4'hF;
        end
        default: o.walkRed = 4'hF;
      endcase
    end
    return o;
  endfunction

endpackage

// File: rtl/tl_timebase.sv
module tl_timebase
  import tl_pkg::*;
#(
  parameter int DIV_COUNT   = 4000000,
  parameter int GO_TICKS    = 5,
  parameter int AMBER_TICKS = 2,
  parameter int CLEAR_TICKS = 1,
  parameter int START_TICKS = 1
) (
  input  logic  clk,
  input  logic  rst,
  input  ctrl_s ctrl,
  output logic  tick,
  output logic  phaseDone
);
  localparam int DW   = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam int MAX1 = (GO_TICKS > AMBER_TICKS) ? GO_TICKS : AMBER_TICKS;
  localparam int MAX2 = (CLEAR_TICKS > START_TICKS) ? CLEAR_TICKS : START_TICKS;
  localparam int MAXT = (MAX1 > MAX2) ? MAX1 : MAX2;
  localparam int TW   = $clog2(MAXT + 1);

  logic [DW-1:0] divCnt;
  logic [TW-1:0] phaseCnt;
  logic [TW-1:0] limit;

  assign tick = (divCnt == DW'(DIV_COUNT - 1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    case (ctrl.kind)
      PK_GO:   limit = TW'(GO_TICKS);
      PK_AMB:  limit = TW'(AMBER_TICKS);
      PK_CLR:  limit = TW'(CLEAR_TICKS);
      default: limit = TW'(START_TICKS);
    endcase
  end

  assign phaseDone = (phaseCnt == limit - TW'(1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst)               phaseCnt <= '0;
    else if (ctrl.advance) phaseCnt <= '0;
    else if (tick)         phaseCnt <= phaseCnt + 1'b1;
  end
endmodule

// File: rtl/tl_sequencer.sv
module tl_sequencer
  import tl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   phaseDone,
  output ctrl_s  ctrl,
  output phase_e stateNow,
  output lamp_s  lamps
);
  phase_e stateNext;

  always_comb begin
    if (stateNow == ST_E_CLR) stateNext = ST_S_GO;
    else                      stateNext = phase_e'(stateNow + 4'd1);
  end

  assign ctrl.advance = tick && phaseDone;
  assign ctrl.kind    = kindOf(stateNow);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stateNow <= ST_START;
      lamps    <= lampsFor(ST_START);
    end else if (ctrl.advance) begin
      stateNow <= stateNext;
      lamps    <= lampsFor(stateNext);
    end
  end
endmodule

// File: rtl/tl_junction.sv
module tl_junction
  import tl_pkg::*;
#(
  parameter int DIV_COUNT   = 4000000,
  parameter int GO_TICKS    = 5,
  parameter int AMBER_TICKS = 2,
  parameter int CLEAR_TICKS = 1,
  parameter int START_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst,
  output logic [3:0] turnLeft,
  output logic [3:0] goStraight,
  output logic [3:0] turnRight,
  output logic [3:0] amber,
  output logic [3:0] stopRed,
  output logic [3:0] walkRed,
  output logic [3:0] walkGreen
);
  ctrl_s  ctrl;
  logic   tick;
  logic   phaseDone;
  phase_e stateNow;
  lamp_s  lamps;

  tl_timebase #(
    .DIV_COUNT(DIV_COUNT), .GO_TICKS(GO_TICKS), .AMBER_TICKS(AMBER_TICKS),
    .CLEAR_TICKS(CLEAR_TICKS), .START_TICKS(START_TICKS)
  ) u_timebase (
    .clk(clk), .rst(rst), .ctrl(ctrl), .tick(tick), .phaseDone(phaseDone)
  );

  tl_sequencer u_seq (
    .clk(clk), .rst(rst), .tick(tick), .phaseDone(phaseDone),
    .ctrl(ctrl), .stateNow(stateNow), .lamps(lamps)
  );

  assign turnLeft   = lamps.left;
  assign goStraight = lamps.straight;
  assign turnRight  = lamps.right;
  assign amber      = lamps.amber;
  assign stopRed    = lamps.red;
  assign walkRed    = lamps.walkRed;
  assign walkGreen  = lamps.walkGreen;
endmodule

// File: rtl/tl_junction_checker.sv
module tl_junction_checker
  import tl_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input phase_e     stateNow,
  input logic [3:0] turnLeft,
  input logic [3:0] goStraight,
  input logic [3:0] turnRight,
  input logic [3:0] amber,
  input logic [3:0] stopRed,
  input logic [3:0] walkRed,
  input logic [3:0] walkGreen
);
  logic [27:0] allLamps;
  assign allLamps = {turnLeft, goStraight, turnRight, amber, stopRed, walkRed, walkGreen};

  p_one_crossing_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(goStraight | turnRight));

  p_red_vs_straight_r9: assert property (@(posedge clk) disable iff (rst)
    (stopRed & goStraight) == 4'b0);

  p_walk_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    (walkRed & walkGreen) == 4'b0);

  p_single_amber_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(amber) <= 1);

  p_hold_between_ticks_r8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(allLamps));

  p_no_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (stateNow != ST_START) |=> (stateNow != ST_START));
endmodule

bind tl_junction tl_junction_checker u_chk (
  .clk(clk), .rst(rst), .tick(tick), .stateNow(stateNow),
  .turnLeft(turnLeft), .goStraight(goStraight), .turnRight(turnRight),
  .amber(amber), .stopRed(stopRed), .walkRed(walkRed), .walkGreen(walkGreen)
);

// File: tb/tb_tl_junction.sv
module tb_tl_junction;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int GO_T  = 5;
  localparam int AMB_T = 2;
  localparam int CLR_T = 1;
  localparam int STA_T = 1;
  localparam int RUN_CYCLES = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] turnLeft, goStraight, turnRight, amber, stopRed, walkRed, walkGreen;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [27:0] val;
    string       tag;
  } item_t;
  item_t sbq[$];

  tl_junction #(
    .DIV_COUNT(DIV), .GO_TICKS(GO_T), .AMBER_TICKS(AMB_T),
    .CLEAR_TICKS(CLR_T), .START_TICKS(STA_T)
  ) dut (
    .clk(clk), .rst(rst), .turnLeft(turnLeft), .goStraight(goStraight),
    .turnRight(turnRight), .amber(amber), .stopRed(stopRed),
    .walkRed(walkRed), .walkGreen(walkGreen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [27:0] actual();
    return {turnLeft, goStraight, turnRight, amber, stopRed, walkRed, walkGreen};
  endfunction

  // Expected lamp word after a given number of ticks since reset release
  function automatic logic [27:0] expAt(int ticks, output string tag);
    logic [3:0] l, s, r, y, rd, wr, wg, oh;
    int t, per, a, ph;
    l = '0; s = '0; r = '0; y = '0; rd = '0; wr = '0; wg = '0;
    if (ticks < STA_T) begin
      rd = 4'hF; wr = 4'hF; tag = "R1";
    end else begin
      per = GO_T + AMB_T + CLR_T;
      t   = (ticks - STA_T) % (4 * per);
      a   = t / per;
      ph  = t % per;
      oh  = 4'b0001 << a;
      rd  = ~oh;
      l   = oh;
      if (ph < GO_T) begin
        s = oh; r = oh; wg = 4'hF;
        if (a == 0) l[3] = 1'b1;
        tag = "R3 R4 R2 R7 R8";
      end else if (ph < GO_T + AMB_T) begin
        y = oh; wg = 4'hF; tag = "R5 R2 R7 R8";
      end else begin
        wr = 4'hF; tag = "R6 R2 R7 R8";
      end
    end
    return {l, s, r, y, rd, wr, wg};
  endfunction

  task automatic check(string tag, logic [27:0] act, logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: predicts the lamp word seen after each rising edge p
  task automatic pushExpected(int n);
    for (int p = 0; p < n; p++) begin
      item_t it;
      it.val = expAt((p + 1) / DIV, it.tag);
      sbq.push_back(it);
    end
  endtask

  // Monitor: pops one item per cycle and compares away from the edge
  task automatic monitor(int n);
    for (int p = 0; p < n; p++) begin
      item_t it;
      @(posedge clk);
      @(negedge clk);
      it = sbq.pop_front();
      check(it.tag, actual(), it.val);
      // R9 conflict rules, counted as checks of their own
      checks++;
      if (($countones(goStraight | turnRight) > 1) || ((stopRed & goStraight) != 0)) begin
        fails++;
        $display("FAIL R9: actual s=%b r=%b red=%b expected no conflict", goStraight, turnRight, stopRed);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    string tg;
    repeat (3) @(negedge clk);
    check("R1 reset", actual(), expAt(0, tg));
    rst = 1'b0;
    pushExpected(RUN_CYCLES);
    fork
      monitor(RUN_CYCLES);
    join
    // R10: asynchronous reset in mid-sequence
    @(negedge clk);
    #1 rst = 1'b1;
    #1 check("R10 async", actual(), expAt(0, tg));
    @(negedge clk);
    rst = 1'b0;
    repeat (DIV - 1) @(negedge clk);
    check("R10 start held", actual(), expAt(0, tg));
    @(negedge clk);
    check("R10 south green", actual(), expAt(1, tg));
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule